// File: doc/BRIEF.md
# Supervisory Reset and Watchdog Controller

This block is a synchronous supervisor that drives a pair of complementary system reset lines, one active high and one active low. Two sources can hold the system in reset. The first is an undervoltage flag that an external comparator has already turned into a digital level. The second is a watchdog that the supervised logic keeps alive by sending falling edges on a kick input.

When the supply becomes good, reset stays asserted for a power-on delay and is then released. After release, the watchdog measures the time since the last accepted kick. If a timeout passes with no kick, the block asserts reset for one fixed-width pulse. It then re-arms the watchdog without a new power-on delay, so the pulses repeat until kicks come back. A strap input turns off the watchdog alone and leaves undervoltage handling as it is.

All three durations come from one base tick count, `TICK_CYCLES`. The power-on delay is 50 base ticks, the watchdog timeout is 5 and the reset pulse is 1. Before a kick counts, it passes through a two-flop synchronizer and must then hold its new level for `KICK_MIN` sampled cycles. Shorter pulses are treated as glitches.

Top module: `supervisor_reset`

## Requirements
- R1: While `rstSync` is high, `resetHigh` is 1 and `resetLow` is 0. After `rstSync` and `underVolt` fall together, reset stays asserted through the power-on delay.
- R2: In every cycle `resetLow` is the inverse of `resetHigh`.
- R3: While `underVolt` is 1, `resetHigh` is 1 in the same cycle, with no clock edge needed.
- R4: Reset is released at the 50*TICK_CYCLES-th rising edge that samples `underVolt` low. If `underVolt` rises again before then, the count restarts from zero.
- R5: After release, if no kick is accepted, `resetHigh` rises at the 5*TICK_CYCLES-th edge after release or after the last accepted kick.
- R6: A watchdog reset pulse keeps `resetHigh` at 1 for exactly TICK_CYCLES cycles. The watchdog then re-arms, and pulses repeat every 6*TICK_CYCLES cycles while kicks stay absent.
- R7: A kick is a 1-to-0 change on `kickIn` (idle level 1) that is held low for at least KICK_MIN clock cycles. It is accepted at the (2+KICK_MIN)-th edge after the low level is applied, and that edge restarts the timeout count.
- R8: A low pulse on `kickIn` shorter than KICK_MIN cycles does not restart the timeout.
- R9: While `wdogOff` is 1, no watchdog pulse occurs and the timeout count is held at zero. The undervoltage response and the power-on delay still apply.
- R10: Raising `rstSync` while reset is released asserts reset at the next edge, and the full power-on delay follows before reset is released again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstSync | input | 1 | Synchronous system reset, active high |
| underVolt | input | 1 | Digitized supply-low flag, 1 when the supply is too low |
| kickIn | input | 1 | Watchdog refresh input; a held falling edge restarts the timeout |
| wdogOff | input | 1 | Strap that disables the watchdog when 1 |
| resetHigh | output | 1 | System reset, active high |
| resetLow | output | 1 | System reset, active low, always the inverse of resetHigh |

## Verification
A single shared counter holds all of the block's timing, so an error in its clearing or terminal compare appears at the ports as a release or timeout edge that comes one or more cycles early or late. The bench catches that on the first such edge, because it checks the reset level in every cycle around each predicted transition. A wrong filter state would either lose a valid kick, which brings a pulse exactly 5*TICK_CYCLES edges after the previous restart, or accept a glitch, which delays the next pulse. Both show within one timeout period.

// File: rtl/supervisor_pkg.sv
package supervisor_pkg;

  typedef enum logic [1:0] {
    ST_HOLD  = 2'd0,
    ST_RUN   = 2'd1,
    ST_PULSE = 2'd2
  } supState_t;

  typedef struct packed {
    logic cntClr;
  } ctrlStrobe_t;

endpackage

// File: rtl/sup_datapath.sv
module sup_datapath
  import supervisor_pkg::*;
#(
  parameter int TICK_CYCLES = 1000,
  parameter int KICK_MIN    = 3
) (
  input  logic        clk,
  input  logic        rstSync,
  input  logic        kickIn,
  input  ctrlStrobe_t strobe,
  output logic        kickFall,
  output logic        hitPor,
  output logic        hitTmo,
  output logic        hitPw
);
  localparam int POR_LEN = 50 * TICK_CYCLES;
  localparam int TMO_LEN = 5 * TICK_CYCLES;
  localparam int PW_LEN  = TICK_CYCLES;
  localparam int CW      = $clog2(POR_LEN + 1);
  localparam int KW      = $clog2(KICK_MIN + 1);
  localparam logic [KW-1:0] K_LAST = KW'(KICK_MIN - 1);

  logic          kMeta, kSync, kLevel;
  logic [KW-1:0] runLen;
  logic [CW-1:0] cnt;

  // two-flop synchronizer followed by a run-length glitch filter
  always_ff @(posedge clk) begin
    if (rstSync) begin
      kMeta  <= 1'b0;
      kSync  <= 1'b0;
      kLevel <= 1'b0;
      runLen <= '0;
    end else begin
      kMeta <= kickIn;
      kSync <= kMeta;
      if (kSync == kLevel) begin
        runLen <= '0;
      end else if (runLen == K_LAST) begin
        kLevel <= kSync;
        runLen <= '0;
      end else begin
        runLen <= runLen + 1'b1;
      end
    end
  end

  assign kickFall = kLevel & ~kSync & (runLen == K_LAST);

  // shared duration counter
  always_ff @(posedge clk) begin
    if (rstSync || strobe.cntClr) cnt <= '0;
    else                          cnt <= cnt + 1'b1;
  end

  assign hitPor = (cnt == CW'(POR_LEN - 1));
  assign hitTmo = (cnt == CW'(TMO_LEN - 1));
  assign hitPw  = (cnt == CW'(PW_LEN - 1));

endmodule

// File: rtl/sup_control.sv
module sup_control
  import supervisor_pkg::*;
(
  input  logic        clk,
  input  logic        rstSync,
  input  logic        underVolt,
  input  logic        wdogOff,
  input  logic        kickFall,
  input  logic        hitPor,
  input  logic        hitTmo,
  input  logic        hitPw,
  output ctrlStrobe_t strobe,
  output supState_t   curState,
  output logic        resetHigh
);
  supState_t nextState;

  always_comb begin
    nextState     = curState;
    strobe.cntClr = 1'b0;
    if (rstSync || underVolt) begin
      nextState     = ST_HOLD;
      strobe.cntClr = 1'b1;
    end else begin
      unique case (curState)
        ST_HOLD: begin
          if (hitPor) begin
            nextState     = ST_RUN;
            strobe.cntClr = 1'b1;
          end
        end
        ST_RUN: begin
          if (kickFall || wdogOff) begin
            strobe.cntClr = 1'b1;
          end else if (hitTmo) begin
            nextState     = ST_PULSE;
            strobe.cntClr = 1'b1;
          end
        end
        ST_PULSE: begin
          if (hitPw) begin
            nextState     = ST_RUN;
            strobe.cntClr = 1'b1;
          end
        end
        default: begin
          nextState     = ST_HOLD;
          strobe.cntClr = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rstSync) curState <= ST_HOLD;
    else         curState <= nextState;
  end

  // undervoltage reaches the output without waiting for an edge
  assign resetHigh = underVolt | (curState != ST_RUN);

endmodule

// File: rtl/supervisor_reset.sv
module supervisor_reset
  import supervisor_pkg::*;
#(
  parameter int TICK_CYCLES = 1000,
  parameter int KICK_MIN    = 3
) (
  input  logic clk,
  input  logic rstSync,
  input  logic underVolt,
  input  logic kickIn,
  input  logic wdogOff,
  output logic resetHigh,
  output logic resetLow
);
  ctrlStrobe_t strobe;
  supState_t   curState;
  logic        kickFall, hitPor, hitTmo, hitPw;

  sup_datapath #(.TICK_CYCLES(TICK_CYCLES), .KICK_MIN(KICK_MIN)) u_dp (
    .clk      (clk),
    .rstSync  (rstSync),
    .kickIn   (kickIn),
    .strobe   (strobe),
    .kickFall (kickFall),
    .hitPor   (hitPor),
    .hitTmo   (hitTmo),
    .hitPw    (hitPw)
  );

  sup_control u_ctl (
    .clk       (clk),
    .rstSync   (rstSync),
    .underVolt (underVolt),
    .wdogOff   (wdogOff),
    .kickFall  (kickFall),
    .hitPor    (hitPor),
    .hitTmo    (hitTmo),
    .hitPw     (hitPw),
    .strobe    (strobe),
    .curState  (curState),
    .resetHigh (resetHigh)
  );

  assign resetLow = ~resetHigh;

endmodule

// File: rtl/supervisor_reset_chk.sv
module supervisor_reset_chk
  import supervisor_pkg::*;
(
  input logic      clk,
  input logic      rstSync,
  input logic      underVolt,
  input logic      wdogOff,
  input logic      resetHigh,
  input logic      resetLow,
  input supState_t curState
);
  // R2
  complement_chk: assert property (@(posedge clk) disable iff (rstSync)
    resetHigh != resetLow);

  // R3
  uv_forces_chk: assert property (@(posedge clk) disable iff (rstSync)
    underVolt |-> resetHigh);

  // R4
  release_quiet_chk: assert property (@(posedge clk) disable iff (rstSync)
    $fell(resetHigh) |-> (!$past(underVolt) && !$past(rstSync)));

  // R9
  wdoff_no_pulse_chk: assert property (@(posedge clk) disable iff (rstSync)
    (curState == ST_RUN && wdogOff && !underVolt) |=> (curState != ST_PULSE));

  // R6
  pulse_rearm_chk: assert property (@(posedge clk) disable iff (rstSync)
    (curState == ST_PULSE && !underVolt) |=> (curState != ST_HOLD));

  // R6
  pulse_drives_chk: assert property (@(posedge clk) disable iff (rstSync)
    (curState == ST_PULSE) |-> resetHigh);
endmodule

bind supervisor_reset supervisor_reset_chk u_chk (
  .clk       (clk),
  .rstSync   (rstSync),
  .underVolt (underVolt),
  .wdogOff   (wdogOff),
  .resetHigh (resetHigh),
  .resetLow  (resetLow),
  .curState  (curState)
);

// File: tb/supervisor_reset_test.sv
`timescale 1ns/1ps
module supervisor_reset_test;
  localparam int TICK = 4;
  localparam int KMIN = 3;
  localparam int POR  = 50 * TICK;
  localparam int NV   = 26;

  logic clk = 1'b0;
  logic rstSync, underVolt, kickIn, wdogOff;
  logic resetHigh, resetLow;
  int   total = 0;
  int   bad   = 0;
  bit   done  = 0;

  always #2 clk = ~clk;

  supervisor_reset #(.TICK_CYCLES(TICK), .KICK_MIN(KMIN)) uut (
    .clk(clk), .rstSync(rstSync), .underVolt(underVolt), .kickIn(kickIn),
    .wdogOff(wdogOff), .resetHigh(resetHigh), .resetLow(resetLow)
  );

  // {kickIn, wdogOff, expected resetHigh, cycles}; starts just after a release
  localparam logic [11:0] VEC [NV] = '{
    {1'b1,1'b0,1'b0,9'd19}, {1'b1,1'b0,1'b1,9'd1},  {1'b1,1'b0,1'b1,9'd3},  {1'b1,1'b0,1'b0,9'd1},
    {1'b0,1'b0,1'b0,9'd5},  {1'b1,1'b0,1'b0,9'd5},  {1'b0,1'b0,1'b0,9'd5},  {1'b1,1'b0,1'b0,9'd5},
    {1'b0,1'b0,1'b0,9'd5},  {1'b1,1'b0,1'b0,9'd5},  {1'b0,1'b0,1'b0,9'd5},  {1'b1,1'b0,1'b0,9'd5},
    {1'b1,1'b0,1'b0,9'd14}, {1'b1,1'b0,1'b1,9'd1},  {1'b1,1'b0,1'b1,9'd3},  {1'b1,1'b0,1'b0,9'd1},
    {1'b0,1'b0,1'b0,9'd2},  {1'b1,1'b0,1'b0,9'd17}, {1'b1,1'b0,1'b1,9'd1},  {1'b1,1'b0,1'b1,9'd3},
    {1'b1,1'b0,1'b0,9'd1},  {1'b1,1'b1,1'b0,9'd60}, {1'b1,1'b0,1'b0,9'd19}, {1'b1,1'b0,1'b1,9'd1},
    {1'b1,1'b0,1'b1,9'd3},  {1'b1,1'b0,1'b0,9'd1}
  };

  function automatic string rowTag(int i);
    if (i < 4)        return "R5 R6 timeout and pulse";
    else if (i < 16)  return "R7 kicks restart timeout";
    else if (i < 21)  return "R8 glitch ignored";
    else              return "R9 watchdog disabled";
  endfunction

  task automatic check(string tag, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expectLevel(string tag, int n, logic exp);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      if (resetHigh !== exp || resetLow !== ~exp) begin
        check(tag, resetHigh, exp);
        return;
      end
    end
    check(tag, resetHigh, exp);
  endtask

  initial begin
    rstSync = 1'b1; underVolt = 1'b1; kickIn = 1'b1; wdogOff = 1'b0;
    step(4);
    check("R1 reset state high", resetHigh, 1'b1);
    check("R1 reset state low", resetLow, 1'b0);
    rstSync = 1'b0; underVolt = 1'b0;
    expectLevel("R1 R4 held through delay", POR - 1, 1'b1);
    expectLevel("R4 released at end of delay", 1, 1'b0);
    check("R2 complement after release", resetLow, 1'b1);

    for (int i = 0; i < NV; i++) begin
      kickIn  = VEC[i][11];
      wdogOff = VEC[i][10];
      expectLevel(rowTag(i), int'(VEC[i][8:0]), VEC[i][9]);
    end

    // undervoltage acts at once
    underVolt = 1'b1; #1;
    check("R3 immediate on undervoltage", resetHigh, 1'b1);
    check("R2 complement on undervoltage", resetLow, 1'b0);
    expectLevel("R3 held during undervoltage", 6, 1'b1);
    underVolt = 1'b0;
    expectLevel("R4 delay after undervoltage", POR - 1, 1'b1);
    expectLevel("R4 release after undervoltage", 1, 1'b0);

    // undervoltage inside the delay restarts it
    underVolt = 1'b1; step(1); underVolt = 1'b0;
    expectLevel("R4 first delay part", 100, 1'b1);
    underVolt = 1'b1; step(1); underVolt = 1'b0;
    expectLevel("R4 restarted delay", POR - 1, 1'b1);
    expectLevel("R4 release after restart", 1, 1'b0);

    // synchronous system reset while released
    rstSync = 1'b1; step(1);
    check("R10 reset at next edge", resetHigh, 1'b1);
    step(1); rstSync = 1'b0;
    expectLevel("R10 delay after system reset", POR - 1, 1'b1);
    expectLevel("R10 release after system reset", 1, 1'b0);

    // strap off: delay still applies, no watchdog pulses
    wdogOff = 1'b1;
    underVolt = 1'b1; step(2); underVolt = 1'b0;
    expectLevel("R9 delay with watchdog off", POR - 1, 1'b1);
    expectLevel("R9 release with watchdog off", 1, 1'b0);
    expectLevel("R9 no pulse while off", 80, 1'b0);
    underVolt = 1'b1; #1;
    check("R9 undervoltage still acts", resetHigh, 1'b1);
    step(1);
    underVolt = 1'b0; wdogOff = 1'b0;

    $display("  test done: total=%0d bad=%0d", total, bad);
    done = 1;
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule